// File: doc/BRIEF.md
# TLB Pair Permission Checker

This block takes one translation entry that has already matched the lookup, plus the access that hit it, and decides what happens to that access. A translation entry covers two adjacent pages, an even half and an odd half. The virtual address bit at the page-size position picks one half. The attributes of that half are then checked against the access kind and the current privilege level in a fixed fault order. The block returns a 3-bit result code, a 48-bit physical address and a 3-bit protection mask.

The entry search, direct-mapped windows and exception raising all sit in neighbouring logic. That logic reads the result code from this block. The page size is a 6-bit shift amount that comes with the entry. A parameter chooses between a registered output stage, which is the default, and a purely combinational path.

Top module: `tlb_pair_guard`

## Requirements
- R1: The odd half is used when bit `pg_shift` of `vaddr` is 1, and the even half when it is 0. A `pg_shift` of 48 or more always selects the even half.
- R2: Each 45-bit half is laid out as follows: valid at bit 0, dirty/writable at bit 1, no-read at bit 2, no-execute at bit 3, a memory-type field at bits 5:4 that has no effect here, the entry privilege at bits 7:6, strict-privilege at bit 8, and the page frame number at bits 44:9.
- R3: Faults are ranked in this order: valid clear gives 3. Otherwise a fetch with no-execute set gives 6. Otherwise a load with no-read set gives 5. Otherwise a privilege failure gives 7. Otherwise a store with dirty clear gives 4. If none of these apply, the result is 0 (success).
- R4: With strict-privilege at 0, privilege fails when `cur_plv` is numerically greater than the entry privilege. With strict-privilege at 1, it fails whenever `cur_plv` differs from the entry privilege.
- R5: `acc_kind` is encoded as 0 = load, 1 = store, 2 = fetch. Code 3 behaves as a load. A no-read bit affects only loads, a no-execute bit only fetches, and a clear dirty bit only stores.
- R6: On success, `paddr` equals the frame number shifted left by 12, ORed with the bits of `vaddr` below `pg_shift`, truncated to 48 bits. A `pg_shift` of 48 or more passes every `vaddr` bit.
- R7: On success, `prot` bit 0 (read) is 1, bit 1 (write) equals dirty, and bit 2 (execute) is the inverse of no-execute. On any fault, `paddr` and `prot` are 0.
- R8: With `REG_OUT` = 1, the outputs reflect the inputs sampled at the previous rising edge. A synchronous reset drives `result` to 3, and `paddr` and `prot` to 0.
- R9: Result codes 1 and 2 are kept for the neighbouring search logic and are never produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset |
| vaddr | input | 48 | Virtual address of the access |
| pg_shift | input | 6 | Page size as a bit position |
| pair_even | input | 45 | Even-page half of the matched entry |
| pair_odd | input | 45 | Odd-page half of the matched entry |
| acc_kind | input | 2 | Access type (0 load, 1 store, 2 fetch, 3 load) |
| cur_plv | input | 2 | Current privilege level |
| result | output | 3 | Outcome code |
| paddr | output | 48 | Physical address, zero on a fault |
| prot | output | 3 | Permission mask {execute, write, read}, zero on a fault |

## Verification
The bench stacks several faults in one half to test the ranking; a design that reorders the checks reports the wrong one of the stacked faults. It tests the privilege rule on both sides of the entry level, in both the relaxed and the strict mode; swapping the comparison or ignoring the strict bit turns a legal access into code 7, or the reverse. It drives the access code 3 and attribute bits that belong to a different access kind; a design that mis-decodes the access kind faults on a load it should pass. It also drives page shifts at 12, beyond 47, and at the exact bit that picks the half; these catch an off-by-one in half selection or in the offset mask, which shows up as the wrong frame or stray offset bits in `paddr`.

// File: rtl/tlbg_pkg.sv
package tlbg_pkg;

  typedef enum logic [2:0] {
    RC_OK      = 3'd0,
    RC_BADVA   = 3'd1,
    RC_MISS    = 3'd2,
    RC_NOVALID = 3'd3,
    RC_NODIRTY = 3'd4,
    RC_NOREAD  = 3'd5,
    RC_NOEXEC  = 3'd6,
    RC_PRIV    = 3'd7
  } rc_e;

  // Bit positions inside one half of an entry pair (decoded by neighbours too)
  localparam int F_V      = 0;
  localparam int F_D      = 1;
  localparam int F_NR     = 2;
  localparam int F_NX     = 3;
  localparam int F_MAT_LO = 4;
  localparam int F_PLV_LO = 6;
  localparam int F_RPLV   = 8;
  localparam int F_PPN_LO = 9;

  localparam int PG_SH = 12;

  typedef struct packed {
    logic       rplv;
    logic [1:0] plv;
    logic       nx;
    logic       nr;
    logic       d;
    logic       v;
  } perm_t;

endpackage

// File: rtl/tlbg_half_select.sv
module tlbg_half_select #(
  parameter int VA_W   = 48,
  parameter int PS_W   = 6,
  parameter int HALF_W = 45
) (
  input  logic [VA_W-1:0]   va,
  input  logic [PS_W-1:0]   ps,
  input  logic [HALF_W-1:0] even_h,
  input  logic [HALF_W-1:0] odd_h,
  output logic [HALF_W-1:0] chosen
);
  localparam logic [PS_W:0] VA_LIM = (PS_W+1)'(VA_W);

  logic pick_odd;

  always_comb begin
    if ({1'b0, ps} < VA_LIM) pick_odd = va[ps];
    else                     pick_odd = 1'b0;
    chosen = pick_odd ? odd_h : even_h;
  end
endmodule

// File: rtl/tlbg_fault_prio.sv
module tlbg_fault_prio
  import tlbg_pkg::*;
(
  input  perm_t      attr,
  input  logic [1:0] acc,
  input  logic [1:0] cur_plv,
  output rc_e        code
);
  logic is_load, is_store, is_fetch, priv_bad;

  always_comb begin
    is_load  = 1'b0;
    is_store = 1'b0;
    is_fetch = 1'b0;
    case (acc)
      2'd1:    is_store = 1'b1;
      2'd2:    is_fetch = 1'b1;
      default: is_load  = 1'b1;
    endcase

    if (attr.rplv) priv_bad = (cur_plv != attr.plv);
    else           priv_bad = (cur_plv >  attr.plv);

    if (!attr.v)                   code = RC_NOVALID;
    else if (is_fetch && attr.nx)  code = RC_NOEXEC;
    else if (is_load && attr.nr)   code = RC_NOREAD;
    else if (priv_bad)             code = RC_PRIV;
    else if (is_store && !attr.d)  code = RC_NODIRTY;
    else                           code = RC_OK;
  end
endmodule

// File: rtl/tlbg_addr_form.sv
module tlbg_addr_form
  import tlbg_pkg::*;
#(
  parameter int VA_W  = 48,
  parameter int PA_W  = 48,
  parameter int PS_W  = 6,
  parameter int PPN_W = 36
) (
  input  logic [PPN_W-1:0] ppn,
  input  logic [VA_W-1:0]  va,
  input  logic [PS_W-1:0]  ps,
  input  logic             dirty,
  input  logic             no_exec,
  input  logic             ok,
  output logic [PA_W-1:0]  pa,
  output logic [2:0]       prot
);
  localparam logic [PS_W:0] PS_LIM = (PS_W+1)'(PA_W);

  logic [PA_W-1:0] base, mask, va_ext;

  always_comb begin
    base   = PA_W'({ppn, {PG_SH{1'b0}}});
    va_ext = PA_W'(va);
    if ({1'b0, ps} >= PS_LIM) mask = '1;
    else                      mask = (PA_W'(1) << ps) - PA_W'(1);

    if (ok) begin
      pa   = base | (va_ext & mask);
      prot = {~no_exec, dirty, 1'b1};
    end else begin
      pa   = '0;
      prot = '0;
    end
  end
endmodule

// File: rtl/tlb_pair_guard.sv
module tlb_pair_guard
  import tlbg_pkg::*;
#(
  parameter int VA_W    = 48,
  parameter int PA_W    = 48,
  parameter int PS_W    = 6,
  parameter int PPN_W   = 36,
  parameter bit REG_OUT = 1'b1,
  localparam int HALF_W = F_PPN_LO + PPN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VA_W-1:0]   vaddr,
  input  logic [PS_W-1:0]   pg_shift,
  input  logic [HALF_W-1:0] pair_even,
  input  logic [HALF_W-1:0] pair_odd,
  input  logic [1:0]        acc_kind,
  input  logic [1:0]        cur_plv,
  output logic [2:0]        result,
  output logic [PA_W-1:0]   paddr,
  output logic [2:0]        prot
);
  logic [HALF_W-1:0] chosen;
  perm_t             attr;
  logic [PPN_W-1:0]  ppn;
  rc_e               code_d;
  logic [PA_W-1:0]   pa_d;
  logic [2:0]        prot_d;
  logic              unused_mat;

  tlbg_half_select #(.VA_W(VA_W), .PS_W(PS_W), .HALF_W(HALF_W)) u_sel (
    .va(vaddr), .ps(pg_shift), .even_h(pair_even), .odd_h(pair_odd), .chosen(chosen)
  );

  always_comb begin
    attr.v    = chosen[F_V];
    attr.d    = chosen[F_D];
    attr.nr   = chosen[F_NR];
    attr.nx   = chosen[F_NX];
    attr.plv  = chosen[F_PLV_LO +: 2];
    attr.rplv = chosen[F_RPLV];
    ppn       = chosen[F_PPN_LO +: PPN_W];
  end

  assign unused_mat = ^chosen[F_MAT_LO +: 2];

  tlbg_fault_prio u_prio (
    .attr(attr), .acc(acc_kind), .cur_plv(cur_plv), .code(code_d)
  );

  tlbg_addr_form #(.VA_W(VA_W), .PA_W(PA_W), .PS_W(PS_W), .PPN_W(PPN_W)) u_addr (
    .ppn(ppn), .va(vaddr), .ps(pg_shift), .dirty(attr.d), .no_exec(attr.nx),
    .ok(code_d == RC_OK), .pa(pa_d), .prot(prot_d)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          result <= RC_NOVALID;
          paddr  <= '0;
          prot   <= '0;
        end else begin
          result <= code_d;
          paddr  <= pa_d;
          prot   <= prot_d;
        end
      end
    end else begin : g_comb
      always_comb begin
        result = code_d;
        paddr  = pa_d;
        prot   = prot_d;
      end
    end
  endgenerate
endmodule

// File: rtl/tlbg_checker.sv
module tlbg_checker #(
  parameter int VA_W    = 48,
  parameter int PA_W    = 48,
  parameter int PS_W    = 6,
  parameter bit REG_OUT = 1'b1
) (
  input logic            clk,
  input logic            rst,
  input logic [VA_W-1:0] vaddr,
  input logic [PS_W-1:0] pg_shift,
  input logic [1:0]      acc_kind,
  input logic [2:0]      result,
  input logic [PA_W-1:0] paddr,
  input logic [2:0]      prot
);
  logic            seen;
  logic [1:0]      acc_q;
  logic [VA_W-1:0] va_q;
  logic [PS_W-1:0] ps_q;
  logic [1:0]      acc_e;
  logic [VA_W-1:0] va_e;
  logic [PS_W-1:0] ps_e;

  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b1;
    acc_q <= acc_kind;
    va_q  <= vaddr;
    ps_q  <= pg_shift;
  end

  assign acc_e = REG_OUT ? acc_q : acc_kind;
  assign va_e  = REG_OUT ? va_q  : vaddr;
  assign ps_e  = REG_OUT ? ps_q  : pg_shift;

  p_no_reserved_r9: assert property (@(posedge clk) disable iff (rst)
    seen |-> (result != 3'd1 && result != 3'd2));

  p_read_on_ok_r7: assert property (@(posedge clk) disable iff (rst)
    (seen && result == 3'd0) |-> prot[0]);

  p_zero_on_fault_r7: assert property (@(posedge clk) disable iff (rst)
    (seen && result != 3'd0) |-> (paddr == '0 && prot == 3'd0));

  p_store_writable_r5: assert property (@(posedge clk) disable iff (rst)
    (seen && acc_e == 2'd1 && result == 3'd0) |-> prot[1]);

  p_fetch_codes_r3: assert property (@(posedge clk) disable iff (rst)
    (seen && acc_e == 2'd2) |-> (result != 3'd4 && result != 3'd5));

  p_load_codes_r5: assert property (@(posedge clk) disable iff (rst)
    (seen && (acc_e == 2'd0 || acc_e == 2'd3)) |-> (result != 3'd4 && result != 3'd6));

  p_store_codes_r5: assert property (@(posedge clk) disable iff (rst)
    (seen && acc_e == 2'd1) |-> (result != 3'd5 && result != 3'd6));

  p_page_offset_r6: assert property (@(posedge clk) disable iff (rst)
    (seen && result == 3'd0 && ps_e >= PS_W'(12)) |-> (paddr[11:0] == va_e[11:0]));

  p_reset_state_r8: assert property (@(posedge clk) disable iff (rst)
    (REG_OUT && seen && $past(rst)) |-> (result == 3'd3 && paddr == '0 && prot == 3'd0));
endmodule

bind tlb_pair_guard tlbg_checker #(
  .VA_W(VA_W), .PA_W(PA_W), .PS_W(PS_W), .REG_OUT(REG_OUT)
) u_chk (
  .clk(clk), .rst(rst), .vaddr(vaddr), .pg_shift(pg_shift), .acc_kind(acc_kind),
  .result(result), .paddr(paddr), .prot(prot)
);

// File: tb/tb_tlb_pair_guard.sv
`timescale 1ns/1ps
module tb_tlb_pair_guard;
  logic        clk = 1'b0;
  logic        rst;
  logic [47:0] vaddr;
  logic [5:0]  pg_shift;
  logic [44:0] pair_even, pair_odd;
  logic [1:0]  acc_kind, cur_plv;
  logic [2:0]  result;
  logic [47:0] paddr;
  logic [2:0]  prot;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [53:0] exp_q[$];

  always #10 clk = ~clk;

  tlb_pair_guard dut (
    .clk(clk), .rst(rst), .vaddr(vaddr), .pg_shift(pg_shift), .pair_even(pair_even),
    .pair_odd(pair_odd), .acc_kind(acc_kind), .cur_plv(cur_plv), .result(result),
    .paddr(paddr), .prot(prot)
  );

  function automatic logic [44:0] mk(input bit v, input bit d, input bit nr, input bit nx,
                                     input logic [1:0] mat, input logic [1:0] plv,
                                     input bit strict, input logic [35:0] ppn);
    return {ppn, strict, plv, mat, nx, nr, d, v};
  endfunction

  // Behavioural reference: returns {code, paddr, prot}
  function automatic logic [53:0] model(input logic [47:0] va, input logic [5:0] ps,
                                        input logic [44:0] ev, input logic [44:0] od,
                                        input logic [1:0] acc, input logic [1:0] lvl);
    logic [44:0] h;
    int code;
    bit ld, st, fe, bad;
    logic [47:0] msk, pa;
    logic [2:0] pr;
    h  = (ps < 48 && ((va >> ps) & 48'd1) == 48'd1) ? od : ev;
    ld = (acc == 2'd0) || (acc == 2'd3);
    st = (acc == 2'd1);
    fe = (acc == 2'd2);
    bad = h[8] ? (lvl != h[7:6]) : (lvl > h[7:6]);
    if (!h[0])             code = 3;
    else if (fe && h[3])   code = 6;
    else if (ld && h[2])   code = 5;
    else if (bad)          code = 7;
    else if (st && !h[1])  code = 4;
    else                   code = 0;
    pa = '0;
    pr = '0;
    if (code == 0) begin
      msk = (ps >= 48) ? {48{1'b1}} : ((48'd1 << ps) - 48'd1);
      pa  = {h[44:9], 12'd0} | (va & msk);
      pr  = {~h[3], h[1], 1'b1};
    end
    return {3'(code), pa, pr};
  endfunction

  task automatic expect_now(input logic [53:0] exp, input string tag);
    checks++;
    if ({result, paddr, prot} !== exp) begin
      fails++;
      $display("FAIL %s: got code=%0d pa=%h prot=%b, expected code=%0d pa=%h prot=%b",
               tag, result, paddr, prot, exp[53:51], exp[50:3], exp[2:0]);
    end
  endtask

  // Drive at a falling edge, compare at the next falling edge (one register stage)
  task automatic step(input logic [47:0] va, input logic [5:0] ps, input logic [44:0] ev,
                      input logic [44:0] od, input logic [1:0] acc, input logic [1:0] lvl,
                      input string tag);
    vaddr = va; pg_shift = ps; pair_even = ev; pair_odd = od; acc_kind = acc; cur_plv = lvl;
    exp_q.push_back(model(va, ps, ev, od, acc, lvl));
    @(negedge clk);
    expect_now(exp_q.pop_front(), tag);
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [44:0] ea, ob, h0, h1;
    logic [53:0] prev;
    rst = 1'b1; vaddr = '0; pg_shift = '0; pair_even = '0; pair_odd = '0;
    acc_kind = '0; cur_plv = '0;
    repeat (3) @(negedge clk);
    expect_now({3'd3, 48'd0, 3'd0}, "R8 reset state");
    rst = 1'b0;

    ea = mk(1, 1, 0, 0, 2'd3, 2'd3, 0, 36'h0_AAAA_5555);
    ob = mk(1, 1, 0, 0, 2'd1, 2'd3, 0, 36'h9_1234_5678);
    step(48'h0000_1234_4ABC, 6'd14, ea, ob, 2'd0, 2'd0, "R1 odd half, R2 layout");
    step(48'h0000_1234_0ABC, 6'd14, ea, ob, 2'd0, 2'd0, "R1 even half");
    step(48'hFFFF_FFFF_FFFF, 6'd50, ea, ob, 2'd0, 2'd0, "R1 shift beyond VA selects even, R6");

    // R8 latency: new inputs do not show before the next rising edge
    prev = {result, paddr, prot};
    vaddr = 48'h0000_1234_4ABC; pg_shift = 6'd14; acc_kind = 2'd0;
    #3;
    expect_now(prev, "R8 outputs hold until clock edge");
    @(negedge clk);
    expect_now(model(48'h0000_1234_4ABC, 6'd14, ea, ob, 2'd0, 2'd0), "R8 one-cycle latency");

    h0 = mk(0, 0, 1, 1, 2'd0, 2'd0, 1, 36'h1);
    step(48'h0, 6'd12, h0, h0, 2'd2, 2'd3, "R3 invalid outranks all");
    h0 = mk(1, 0, 1, 1, 2'd0, 2'd0, 1, 36'h1);
    step(48'h0, 6'd12, h0, h0, 2'd2, 2'd3, "R3 no-exec outranks privilege");
    step(48'h0, 6'd12, h0, h0, 2'd0, 2'd3, "R3 no-read outranks privilege");
    step(48'h0, 6'd12, h0, h0, 2'd1, 2'd3, "R3 privilege outranks dirty");
    h0 = mk(1, 0, 0, 0, 2'd0, 2'd3, 0, 36'h2);
    step(48'h0, 6'd12, h0, h0, 2'd1, 2'd1, "R3 store to clean page");

    h0 = mk(1, 1, 0, 0, 2'd0, 2'd2, 0, 36'h3);
    step(48'h123, 6'd12, h0, h0, 2'd0, 2'd1, "R4 relaxed lower level passes");
    step(48'h123, 6'd12, h0, h0, 2'd0, 2'd3, "R4 relaxed higher level faults");
    h1 = mk(1, 1, 0, 0, 2'd0, 2'd2, 1, 36'h3);
    step(48'h123, 6'd12, h1, h1, 2'd0, 2'd0, "R4 strict lower level faults");
    step(48'h123, 6'd12, h1, h1, 2'd0, 2'd2, "R4 strict equal level passes");

    h0 = mk(1, 1, 1, 0, 2'd0, 2'd3, 0, 36'h4);
    step(48'h7, 6'd12, h0, h0, 2'd3, 2'd0, "R5 code 3 is a load");
    step(48'h7, 6'd12, h0, h0, 2'd1, 2'd0, "R5 no-read ignored for store");
    h0 = mk(1, 1, 0, 1, 2'd0, 2'd3, 0, 36'h4);
    step(48'h7, 6'd12, h0, h0, 2'd3, 2'd0, "R5 no-exec ignored for load");
    h0 = mk(1, 0, 0, 0, 2'd0, 2'd3, 0, 36'h4);
    step(48'h7, 6'd12, h0, h0, 2'd2, 2'd0, "R5 clean page ignored for fetch");

    h0 = mk(1, 1, 0, 0, 2'd0, 2'd3, 0, 36'hF_FFFF_FFFF);
    step(48'hABCD_EF01_2FFF, 6'd12, h0, h0, 2'd0, 2'd0, "R6 smallest offset");
    step(48'h0123_4567_89AB, 6'd63, h0, h0, 2'd0, 2'd0, "R6 full offset");
    h0 = mk(1, 0, 0, 1, 2'd0, 2'd3, 0, 36'h5);
    step(48'h9, 6'd13, h0, h0, 2'd0, 2'd0, "R7 read-only no-exec mask");

    for (int i = 0; i < 500; i++) begin
      logic [47:0] va;
      va = {$urandom, $urandom};
      h0 = 45'({$urandom, $urandom});
      h1 = 45'({$urandom, $urandom});
      if (i % 3 != 0) begin h0[0] = 1'b1; h1[0] = 1'b1; end
      step(va, 6'($urandom_range(10, 50)), h0, h1, 2'($urandom), 2'($urandom),
           "R1/R3/R4/R6/R7 random");
      checks++;
      if (result == 3'd1 || result == 3'd2) begin
        fails++;
        $display("FAIL R9: got code=%0d, expected neither 1 nor 2", result);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule